// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block is the digital control logic in front of a successive-approximation converter. It decides when a conversion starts, times it, and files the result. There are three start sources: a software start bit, the falling edge of an external trigger pin, and a one-cycle pulse from a timer. The external pin is synchronized by two flops before its falling edge is detected.

Once started, a conversion runs for a fixed number of converter clock cycles. The count depends on the resolution (8 or 10 bits) and on whether sample-and-hold is in use. A hardware trigger that arrives while a conversion is running discards that conversion and starts a fresh one. Clearing the start bit abandons the conversion.

At completion, the sample value from the converter model is written into one of eight result registers. In DMA mode every result goes to register 0 and a one-cycle transfer request is raised. A width flag tells the DMA engine whether to move 8 or 16 bits.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `dma_req_o` and `dma_w16_o` are 0, and all eight result registers read 0.
- R2: The trigger select `{trg_sel_a_i, trg_sel_b_i}` is decoded as follows: 00 or 01 selects software mode, 10 selects the external pin, and 11 selects the timer. In software mode a 0-to-1 transition of `start_i` starts a conversion at that clock edge, so `busy_o` is 1 in the following cycle.
- R3: In external mode with `start_i` at 1, a falling edge of `ext_trg_i` starts a conversion. `busy_o` first reads 1 after the third rising clock edge that samples the pin low.
- R4: In timer mode with `start_i` at 1, `tmr_pulse_i` sampled high at a clock edge starts a conversion at that edge.
- R5: Hardware triggers have no effect while `start_i` is 0. A 0-to-1 transition of `start_i` does not start a conversion in external or timer mode.
- R6: A conversion keeps `busy_o` at 1 for exactly L cycles. With sample-and-hold, L is 28 at 8 bits and 33 at 10 bits. Without it, L is a parameter, 49 at 8 bits and 59 at 10 bits by default. Resolution, sample-and-hold, DMA mode and channel are captured when the conversion starts.
- R7: A hardware trigger during a conversion abandons it without a done pulse and restarts it. `busy_o` then stays 1 for a full L cycles counted from the restart.
- R8: When `start_i` is 0 at a clock edge, `busy_o` is 0 after that edge and no done pulse or result write follows.
- R9: `done_o` is a one-cycle pulse in the cycle after the last busy cycle. The result register is updated in that same cycle.
- R10: The write takes `sample_i` as it stands at the last busy edge. A 10-bit result is {6'b0, `sample_i`[9:0]}. An 8-bit result is {8'b0, `sample_i`[9:2]}, so bits 15:8 are zero.
- R11: Without DMA mode, only the result register at the captured channel index (0 to 7) is written. All other registers keep their values.
- R12: In DMA mode, register 0 is written whatever the channel, and `dma_req_o` pulses together with `done_o`. Without DMA mode, `dma_req_o` stays 0.
- R13: `dma_w16_o` equals the resolution captured at the most recent start: 1 for 10-bit, 0 for 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Software start / enable bit |
| trg_sel_a_i | input | 1 | Trigger select, first bit |
| trg_sel_b_i | input | 1 | Trigger select, second bit |
| ext_trg_i | input | 1 | External trigger pin (asynchronous) |
| tmr_pulse_i | input | 1 | Timer trigger pulse |
| res10_i | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| sh_en_i | input | 1 | Sample-and-hold enable |
| dma_en_i | input | 1 | DMA mode enable |
| chan_i | input | 3 | Channel index of the result |
| sample_i | input | 10 | Sample value from converter model |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion completed pulse |
| dma_req_o | output | 1 | DMA transfer request pulse |
| dma_w16_o | output | 1 | DMA width: 1 = 16-bit, 0 = 8-bit |
| res_o | output | 8x16 | Result register bank |

## Verification
The bench builds the block with its default parameters. That means eight result registers and conversion lengths of 28, 33, 49 and 59 cycles, so every length the resolution and sample-and-hold settings can select is measured against an expected count. With these defaults, a run fits a randomized series of conversions across all three trigger modes, both resolutions and DMA mode. Directed cases cover restart in the middle of a conversion, abort by clearing the start bit, and triggers that must be ignored.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    TRG_SW  = 2'd0,
    TRG_EXT = 2'd1,
    TRG_TMR = 2'd2
  } trg_mode_e;

  function automatic trg_mode_e decode_trg(input logic sel_a, input logic sel_b);
    if (!sel_a)      return TRG_SW;
    else if (!sel_b) return TRG_EXT;
    else             return TRG_TMR;
  endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic ext_trg_i,
  input  logic tmr_pulse_i,
  output logic start_evt_o
);

  logic [1:0] sync_q;
  logic       prev_q;
  logic       start_q;
  logic       ext_fall;
  trg_mode_e  mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      start_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], ext_trg_i};
      prev_q  <= sync_q[1];
      start_q <= start_i;
    end
  end

  assign ext_fall = prev_q & ~sync_q[1];
  assign mode     = decode_trg(sel_a_i, sel_b_i);

  always_comb begin
    unique case (mode)
      TRG_EXT: start_evt_o = start_i & ext_fall;
      TRG_TMR: start_evt_o = start_i & tmr_pulse_i;
      default: start_evt_o = start_i & ~start_q;
    endcase
  end

  // R5
  evt_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt_o |-> start_i);

  // R3
  ext_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_evt_o && mode == TRG_EXT) |-> ($past(sync_q[0]) == 1'b0));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int LEN_SH8  = 28,
  parameter int LEN_SH10 = 33,
  parameter int LEN_NS8  = 49,
  parameter int LEN_NS10 = 59,
  parameter int CNT_W    = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_evt_i,
  input  logic res10_i,
  input  logic sh_en_i,
  output logic busy_o,
  output logic done_o,
  output logic fin_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_sel;
  logic             busy_q;
  logic             done_q;
  logic             last;

  always_comb begin
    unique case ({sh_en_i, res10_i})
      2'b11:   len_sel = CNT_W'(LEN_SH10);
      2'b10:   len_sel = CNT_W'(LEN_SH8);
      2'b01:   len_sel = CNT_W'(LEN_NS10);
      default: len_sel = CNT_W'(LEN_NS8);
    endcase
  end

  assign last  = busy_q && (cnt_q == len_q - CNT_W'(1));
  // a new trigger on the final edge wins over completion
  assign fin_o = last && start_i && !start_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= CNT_W'(LEN_NS8);
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!start_i) begin
        busy_q <= 1'b0;
      end else if (start_evt_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        len_q  <= len_sel;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < len_q));

  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!busy_q && !done_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)) ##1 !done_q);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_RES = 8,
  parameter int SMP_W   = 10,
  parameter int RES_W   = 16,
  parameter int LO_W    = 8,
  parameter int CH_W    = $clog2(NUM_RES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [SMP_W-1:0]                sample_i,
  input  logic                            res10_i,
  input  logic                            dma_i,
  input  logic [CH_W-1:0]                 chan_i,
  output logic [NUM_RES-1:0][RES_W-1:0]   res_o,
  output logic                            dma_req_o
);

  logic [NUM_RES-1:0][RES_W-1:0] res_q;
  logic [RES_W-1:0]              data;
  logic [CH_W-1:0]               idx;
  logic                          req_q;

  assign idx  = dma_i ? '0 : chan_i;
  assign data = res10_i ? RES_W'(sample_i) : RES_W'(sample_i[SMP_W-1 -: LO_W]);

  for (genvar g = 0; g < NUM_RES; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         res_q[g] <= '0;
      else if (wr_i && idx == CH_W'(g))    res_q[g] <= data;
    end

    // R10
    narrow_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !res10_i && idx == CH_W'(g)) |=> (res_q[g][RES_W-1:LO_W] == '0));

    if (g != 0) begin : g_dma
      // R12
      dma_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && dma_i) |=> $stable(res_q[g]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= wr_i & dma_i;
  end

  assign res_o     = res_q;
  assign dma_req_o = req_q;

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
  parameter int NUM_RES  = 8,
  parameter int SMP_W    = 10,
  parameter int RES_W    = 16,
  parameter int LO_W     = 8,
  parameter int LEN_SH8  = 28,
  parameter int LEN_SH10 = 33,
  parameter int LEN_NS8  = 49,
  parameter int LEN_NS10 = 59
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          trg_sel_a_i,
  input  logic                          trg_sel_b_i,
  input  logic                          ext_trg_i,
  input  logic                          tmr_pulse_i,
  input  logic                          res10_i,
  input  logic                          sh_en_i,
  input  logic                          dma_en_i,
  input  logic [$clog2(NUM_RES)-1:0]    chan_i,
  input  logic [SMP_W-1:0]              sample_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          dma_req_o,
  output logic                          dma_w16_o,
  output logic [NUM_RES-1:0][RES_W-1:0] res_o
);

  localparam int CH_W  = $clog2(NUM_RES);
  localparam int MAX_A = (LEN_SH8 > LEN_SH10) ? LEN_SH8 : LEN_SH10;
  localparam int MAX_B = (LEN_NS8 > LEN_NS10) ? LEN_NS8 : LEN_NS10;
  localparam int LMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(LMAX + 1);

  logic            start_evt;
  logic            fin;
  logic            res10_q, dma_q;
  logic [CH_W-1:0] chan_q;

  adc_trig_sel i_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sel_a_i     (trg_sel_a_i),
    .sel_b_i     (trg_sel_b_i),
    .ext_trg_i   (ext_trg_i),
    .tmr_pulse_i (tmr_pulse_i),
    .start_evt_o (start_evt)
  );

  // conversion settings captured at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res10_q <= 1'b0;
      dma_q   <= 1'b0;
      chan_q  <= '0;
    end else if (start_evt) begin
      res10_q <= res10_i;
      dma_q   <= dma_en_i;
      chan_q  <= chan_i;
    end
  end

  adc_conv_timer #(
    .LEN_SH8  (LEN_SH8),
    .LEN_SH10 (LEN_SH10),
    .LEN_NS8  (LEN_NS8),
    .LEN_NS10 (LEN_NS10),
    .CNT_W    (CNT_W)
  ) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_evt_i (start_evt),
    .res10_i     (res10_i),
    .sh_en_i     (sh_en_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fin_o       (fin)
  );

  adc_result_bank #(
    .NUM_RES (NUM_RES),
    .SMP_W   (SMP_W),
    .RES_W   (RES_W),
    .LO_W    (LO_W),
    .CH_W    (CH_W)
  ) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (fin),
    .sample_i  (sample_i),
    .res10_i   (res10_q),
    .dma_i     (dma_q),
    .chan_i    (chan_q),
    .res_o     (res_o),
    .dma_req_o (dma_req_o)
  );

  assign dma_w16_o = res10_q;

  // R12
  dma_req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> done_o);

  // R7
  restart_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_evt) |=> (busy_o && !done_o));

endmodule

// File: tb/test_adc_trig_ctrl.sv
module test_adc_trig_ctrl;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0, sel_a = 1'b0, sel_b = 1'b0;
  logic              ext = 1'b1, tmr = 1'b0;
  logic              res10 = 1'b0, sh = 1'b0, dma = 1'b0;
  logic [2:0]        chan = '0;
  logic [9:0]        sample = '0;
  logic              busy, done, dreq, w16;
  logic [7:0][15:0]  res;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [15:0] model [8];

  always #4 clk = ~clk;

  adc_trig_ctrl i_adc_trig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .trg_sel_a_i(sel_a), .trg_sel_b_i(sel_b),
    .ext_trg_i(ext), .tmr_pulse_i(tmr),
    .res10_i(res10), .sh_en_i(sh), .dma_en_i(dma),
    .chan_i(chan), .sample_i(sample),
    .busy_o(busy), .done_o(done), .dma_req_o(dreq),
    .dma_w16_o(w16), .res_o(res)
  );

  function automatic int exp_len(bit r10, bit s);
    if (s) return r10 ? 33 : 28;
    return r10 ? 59 : 49;
  endfunction

  function automatic logic [15:0] exp_res(bit r10, logic [9:0] smp);
    return r10 ? {6'b0, smp} : {8'b0, smp[9:2]};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output int n, output bit gd, output bit dr);
    n = 0; gd = 0; dr = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin gd = 1; dr = dreq; break; end
      if (busy) n++;
      @(negedge clk);
    end
  endtask

  task automatic check_bank(string req);
    for (int k = 0; k < 8; k++)
      chk(res[k] == model[k], req, $sformatf("reg%0d", k), res[k], model[k]);
  endtask

  // mode: 0 software, 1 external, 2 timer
  task automatic conv(int mode, bit r10, bit s, bit d, logic [2:0] ch,
                      logic [9:0] smp, string req);
    int lat, n, el;
    bit gd, dr;
    logic [2:0] idx;
    @(negedge clk);
    start = 0; res10 = r10; sh = s; dma = d; chan = ch; sample = smp;
    sel_a = (mode != 0); sel_b = (mode == 2);
    @(negedge clk);
    start = 1;
    if (mode == 1) begin @(negedge clk); ext = 0; end
    if (mode == 2) begin @(negedge clk); tmr = 1; end
    lat = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      tmr = 0;
      lat++;
      if (busy) break;
    end
    // R2 R3 R4 start latency
    el = (mode == 1) ? 3 : 1;
    chk(lat == el, (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4", "start latency", lat, el);
    wait_done(n, gd, dr);
    el = exp_len(r10, s);
    chk(n == el, "R6", "busy length", n, el);
    chk(gd, "R9", "done pulse", gd, 1);
    chk(dr == d, "R12", "dma request", dr, d);
    chk(w16 == r10, "R13", "dma width", w16, r10);
    idx = d ? 3'd0 : ch;
    model[idx] = exp_res(r10, smp);
    chk(res[idx] == model[idx], "R10", "result", res[idx], model[idx]);
    check_bank("R11");
    @(negedge clk);
    chk(!done, "R9", "done single cycle", done, 0);
    start = 0; ext = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    bit gd, dr, seen;
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !dreq && !w16, "R1", "flags", {busy, done, dreq, w16}, 0);
    check_bank("R1");
    rst_n = 1;
    repeat (2) @(negedge clk);

    conv(0, 1, 1, 0, 3'd3, 10'h2A5, "R2");
    conv(0, 0, 1, 0, 3'd6, 10'h3FF, "R10");
    conv(1, 1, 0, 0, 3'd1, 10'h155, "R3");
    conv(2, 0, 0, 0, 3'd7, 10'h0C3, "R4");
    conv(0, 1, 0, 0, 3'd0, 10'h001, "R6");
    conv(2, 1, 1, 1, 3'd5, 10'h3A7, "R12");
    conv(0, 0, 1, 1, 3'd2, 10'h1F0, "R13");
    conv(1, 0, 1, 0, 3'd4, 10'h27C, "R11");

    // R5: timer pulse with start low, and start edge in timer mode
    @(negedge clk);
    sel_a = 1; sel_b = 1; start = 0; tmr = 1;
    @(negedge clk); tmr = 0;
    seen = 0;
    repeat (4) begin @(negedge clk); seen |= busy | done; end
    chk(!seen, "R5", "timer with start low", seen, 0);
    start = 1;
    seen = 0;
    repeat (4) begin @(negedge clk); seen |= busy | done; end
    chk(!seen, "R5", "start edge in timer mode", seen, 0);
    // R5: external edge with start low
    start = 0; sel_b = 0; ext = 0;
    seen = 0;
    repeat (6) begin @(negedge clk); seen |= busy | done; end
    chk(!seen, "R5", "external with start low", seen, 0);
    check_bank("R5");
    ext = 1;
    repeat (4) @(negedge clk);

    // R7: restart by timer pulse mid-conversion
    sel_a = 1; sel_b = 1; res10 = 1; sh = 1; dma = 0; chan = 3'd6; sample = 10'h0AB;
    start = 1;
    @(negedge clk); tmr = 1;
    @(negedge clk); tmr = 0;
    seen = 0;
    repeat (10) begin @(negedge clk); seen |= done; end
    tmr = 1;
    @(negedge clk); tmr = 0;
    seen |= done;
    chk(!seen && busy, "R7", "no done on restart", seen, 0);
    wait_done(n, gd, dr);
    chk(n == 33, "R7", "length after restart", n, 33);
    model[6] = exp_res(1, 10'h0AB);
    chk(res[6] == model[6], "R7", "result after restart", res[6], model[6]);
    start = 0;
    repeat (3) @(negedge clk);

    // R8: abort by clearing start
    sel_a = 0; sel_b = 0; res10 = 0; sh = 0; chan = 3'd2; sample = 10'h3C3;
    @(negedge clk); start = 1;
    repeat (6) @(negedge clk);
    chk(busy, "R8", "busy before abort", busy, 1);
    start = 0;
    @(negedge clk);
    chk(!busy, "R8", "busy after abort", busy, 0);
    seen = 0;
    repeat (60) begin @(negedge clk); seen |= done | busy; end
    chk(!seen, "R8", "no done after abort", seen, 0);
    check_bank("R8");

    // random conversions
    for (int it = 0; it < 24; it++)
      conv($urandom % 3, 1'($urandom), 1'($urandom), 1'($urandom),
           3'($urandom), 10'($urandom), "R6");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule